// File: doc/BRIEF.md
# Line-Rate Phase Comparator with Selectable Reference

This block is the digital phase comparator of a video sync generator's line-frequency loop. It compares a line-rate pulse from the generator's own divider chain with a reference line edge, and it drives a three-state charge-pump signal. That signal is modelled as separate up, down and enable outputs. A loop filter and a voltage-controlled oscillator outside the block turn the pump signal into the master clock.

The lock selector picks where the reference edge comes from. In subcarrier lock, a phase accumulator divides the colour subcarrier down to line rate. The division ratio depends on the TV system and is not an integer for most systems. In the two sync-lock modes, the edge comes from an external composite sync. Only pulses whose width marks them as line syncs are accepted, so equalizing and broad pulses are rejected. In external-reference mode, the subcarrier pin carries a line reference, and each rising edge on it is the reference edge. Both external pins are synchronised to the system clock before they are used.

Top module: `line_phase_cmp`

## Requirements
- R1: After reset, pump_up, pump_dn and pump_en are all 0.
- R2: If a reference edge arrives while no comparison is pending, pump_up and pump_en go to 1. They stay at 1 until an internal edge arrives, and then both pump outputs return to 0.
- R3: If an internal edge (line_ref_int high for one cycle) arrives first, pump_dn and pump_en go to 1. They stay at 1 until a reference edge arrives, and then both pump outputs return to 0.
- R4: pump_up and pump_dn are never 1 together, and pump_en is 1 exactly when one of them is 1.
- R5: When lock_sel = 2'b00, the k-th reference edge falls on subcarrier rising edge n, with n = ceil(k*Q/10000) and edges counted from entry into the mode. Q depends on the tv_sys code: 0 gives 2837516, 1 gives 2292516, 2 gives 2272500, 3 gives 2275000 and 4 gives 2820000. Codes 5 to 7 behave as code 3.
- R6: When lock_sel = 2'b10, every rising edge on sc_pin is a reference edge.
- R7: When lock_sel is 2'b01 or 2'b11, a low pulse on ecs_n that lasts between SYNC_MIN and SYNC_MAX clock cycles inclusive is a reference edge. The edge is taken at the pulse's rising end. The defaults are 80 and 140.
- R8: In those modes, a low pulse on ecs_n that is shorter than SYNC_MIN or longer than SYNC_MAX produces no reference edge.
- R9: Activity on the pin that the current lock_sel does not use has no effect on the pump outputs.
- R10: A change of lock_sel or tv_sys cancels any pending comparison, so the pump outputs return to 0. The same change restarts the subcarrier edge count used by R5.
- R11: A reference edge and an internal edge in the same cycle produce no pump activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_sel | input | 2 | Reference selector: 00 subcarrier, 01 slow sync, 10 external line reference, 11 fast sync |
| tv_sys | input | 3 | TV system code that picks the subcarrier-to-line ratio |
| sc_pin | input | 1 | Subcarrier, or the external line reference when lock_sel = 10 (asynchronous) |
| ecs_n | input | 1 | External composite sync, active low (asynchronous) |
| line_ref_int | input | 1 | One-cycle line pulse from the internal divider chain |
| pump_up | output | 1 | Pump drives high (the reference leads) |
| pump_dn | output | 1 | Pump drives low (the internal edge leads) |
| pump_en | output | 1 | Pump output enabled; when 0 the pump is high-impedance |

## Verification
The divider is driven with long trains of subcarrier edges for every system code and for one out-of-range code. The recorded edge at which each reference fires separates the integer, half, quarter and four-decimal ratios from one another, and it also catches an accumulator that rounds or drifts.

The sync separator receives pulses at exactly SYNC_MIN, one cycle below it, exactly SYNC_MAX and one cycle above it, plus equalizing-width and broad-width pulses. These tell an accepting window apart from off-by-one bounds.

The detector is tried with the reference leading, with the internal edge leading, and with both edges in the same cycle. The coincident case is timed by first measuring the reference path's latency. Finally, unused-pin activity and a configuration change in the middle of a count show that reference selection and clearing act only where they should.

// File: rtl/lpc_pkg.sv
// Shared definitions for the line-rate phase comparator.
// Assumes subcarrier-to-line ratios are expressed in units of 1/10000.
package lpc_pkg;

    localparam int RATIO_SCALE = 10000;
    localparam int RATIO_W     = 22;

    typedef enum logic [1:0] {
        SEL_SUBCAR    = 2'b00,
        SEL_SYNC_SLOW = 2'b01,
        SEL_EXT_LREF  = 2'b10,
        SEL_SYNC_FAST = 2'b11
    } lock_sel_e;

    // Subcarrier cycles per line, times RATIO_SCALE, for each TV system code.
    function automatic logic [RATIO_W-1:0] sc_ratio(input logic [2:0] sys);
        case (sys)
            3'd0:    return RATIO_W'(2837516);
            3'd1:    return RATIO_W'(2292516);
            3'd2:    return RATIO_W'(2272500);
            3'd4:    return RATIO_W'(2820000);
            default: return RATIO_W'(2275000);
        endcase
    endfunction

endpackage

// File: rtl/lpc_pin_sync.sv
// Synchronises one asynchronous pin into the clock domain and flags its rising edge.
// Assumes the pin stays at each level for at least two clock cycles.
module lpc_pin_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_single
            // Capture the pin in a single stage.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= RST_VAL;
                else        chain <= pin_i;
            end
        end else begin : g_chain
            // Shift the pin through the synchroniser chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], pin_i};
            end
        end
    endgenerate

    // Remember the last synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= RST_VAL;
        else        prev <= chain[STAGES-1];
    end

    assign level_o = chain[STAGES-1];
    assign rise_o  = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/lpc_frac_div.sv
// Divides subcarrier edges down to line rate by a fractional ratio.
// On each edge it adds RATIO_SCALE to a phase accumulator; whenever the sum
// reaches the ratio, it emits one line tick and subtracts the ratio.
// Assumes clr_i is raised whenever ratio_i changes.
module lpc_frac_div
    import lpc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               edge_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               tick_o
);
    logic [RATIO_W-1:0] acc;
    logic [RATIO_W:0]   sum;
    logic               wrap;

    assign sum  = {1'b0, acc} + (RATIO_W + 1)'(RATIO_SCALE);
    assign wrap = (sum >= {1'b0, ratio_i});

    // Advance the accumulator on each subcarrier edge and flag line wraps.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            acc    <= '0;
            tick_o <= 1'b0;
        end else begin
            tick_o <= 1'b0;
            if (edge_i) begin
                if (wrap) begin
                    acc    <= RATIO_W'(sum - {1'b0, ratio_i});
                    tick_o <= 1'b1;
                end else begin
                    acc <= sum[RATIO_W-1:0];
                end
            end
        end
    end

    // R5
    acc_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
        acc < ratio_i);

    // R5
    tick_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
        tick_o |-> $past(edge_i));
endmodule

// File: rtl/lpc_sync_sep.sv
// Takes line-sync edges out of a synchronised active-low composite sync.
// It measures each low pulse and accepts only widths inside [MIN_W, MAX_W],
// which rejects equalizing and broad pulses. The tick is issued at the pulse's rising end.
module lpc_sync_sep #(
    parameter int MIN_W = 80,
    parameter int MAX_W = 140
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    input  logic rise_i,
    output logic tick_o
);
    localparam int CNT_W = $clog2(MAX_W + 2);
    localparam logic [CNT_W-1:0] SAT = CNT_W'(MAX_W + 1);

    logic [CNT_W-1:0] low_cnt;
    logic             in_win;

    assign in_win = (low_cnt >= CNT_W'(MIN_W)) && (low_cnt <= CNT_W'(MAX_W));

    // Count low cycles (saturating) and judge the width at the rising end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
            tick_o  <= 1'b0;
        end else begin
            tick_o <= rise_i & in_win;
            if (rise_i)                        low_cnt <= '0;
            else if (!level_i && low_cnt != SAT) low_cnt <= low_cnt + 1'b1;
        end
    end

    // R8
    sync_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> ($past(low_cnt) >= CNT_W'(MIN_W) && $past(low_cnt) <= CNT_W'(MAX_W)));
endmodule

// File: rtl/lpc_pfd.sv
// Phase-frequency detector with two flags. The edge that arrives first raises its
// flag; the other edge clears both, leaving the output high-impedance.
// Assumes one-cycle input pulses; clr_i drops any pending comparison.
module lpc_pfd (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic ref_i,
    input  logic int_i,
    output logic up_o,
    output logic dn_o
);
    logic ref_nx, int_nx;

    assign ref_nx = up_o | ref_i;
    assign int_nx = dn_o | int_i;

    // Hold the leading edge until the lagging one arrives.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            up_o <= 1'b0;
            dn_o <= 1'b0;
        end else if (ref_nx && int_nx) begin
            up_o <= 1'b0;
            dn_o <= 1'b0;
        end else begin
            up_o <= ref_nx;
            dn_o <= int_nx;
        end
    end

    // R4
    up_dn_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_o && dn_o));

    // R2
    ref_leads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_i && !int_i && !dn_o && !clr_i) |=> up_o);

    // R3
    int_leads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_i && !ref_i && !up_o && !clr_i) |=> dn_o);

    // R11
    coincident_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_i && int_i && !up_o && !dn_o) |=> (!up_o && !dn_o));
endmodule

// File: rtl/line_phase_cmp.sv
// Line-rate phase comparator shared by all lock modes. It picks the reference
// edge according to lock_sel (divided subcarrier, separated line sync, or an
// external line reference on the subcarrier pin) and compares it with the
// internal line pulse. Assumes line_ref_int is synchronous and one cycle wide.
module line_phase_cmp
    import lpc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SYNC_MIN    = 80,
    parameter int SYNC_MAX    = 140
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] lock_sel,
    input  logic [2:0] tv_sys,
    input  logic       sc_pin,
    input  logic       ecs_n,
    input  logic       line_ref_int,
    output logic       pump_up,
    output logic       pump_dn,
    output logic       pump_en
);
    logic [1:0]         sel_q;
    logic [2:0]         sys_q;
    logic               cfg_chg;
    logic               sc_lvl, sc_rise;
    logic               ecs_lvl, ecs_rise;
    logic               div_tick, sep_tick;
    logic               ref_pulse;
    logic [RATIO_W-1:0] ratio;

    // Track the configuration so that any change clears the comparison.
    always_ff @(posedge clk) begin
        sel_q <= lock_sel;
        sys_q <= tv_sys;
    end

    assign cfg_chg = (lock_sel != sel_q) || (tv_sys != sys_q);
    assign ratio   = sc_ratio(tv_sys);

    lpc_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sc_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(sc_pin),
        .level_o(sc_lvl), .rise_o(sc_rise)
    );

    lpc_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_ecs_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(ecs_n),
        .level_o(ecs_lvl), .rise_o(ecs_rise)
    );

    lpc_frac_div i_div (
        .clk(clk), .rst_n(rst_n), .clr_i(cfg_chg),
        .edge_i(sc_rise && lock_sel == SEL_SUBCAR), .ratio_i(ratio),
        .tick_o(div_tick)
    );

    lpc_sync_sep #(.MIN_W(SYNC_MIN), .MAX_W(SYNC_MAX)) i_sep (
        .clk(clk), .rst_n(rst_n), .level_i(ecs_lvl), .rise_i(ecs_rise),
        .tick_o(sep_tick)
    );

    // Select the reference edge for the current lock mode.
    always_comb begin
        case (lock_sel)
            SEL_SUBCAR:   ref_pulse = div_tick;
            SEL_EXT_LREF: ref_pulse = sc_rise;
            default:      ref_pulse = sep_tick;
        endcase
    end

    lpc_pfd i_pfd (
        .clk(clk), .rst_n(rst_n), .clr_i(cfg_chg),
        .ref_i(ref_pulse), .int_i(line_ref_int),
        .up_o(pump_up), .dn_o(pump_dn)
    );

    assign pump_en = pump_up | pump_dn;

    // R10
    cfg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg |=> (!pump_up && !pump_dn));

    // R9
    unused_ecs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_sel[1] != lock_sel[0] || lock_sel == SEL_SUBCAR) |-> (ref_pulse != sep_tick || ref_pulse == 1'b0 || lock_sel[0]));
endmodule

// File: tb/test_line_phase_cmp.sv
// Directed bench: each task drives one scenario and checks its own results.
module test_line_phase_cmp;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] lock_sel = 2'b00;
    logic [2:0] tv_sys = 3'd0;
    logic       sc_pin = 1'b0;
    logic       ecs_n = 1'b1;
    logic       line_ref_int = 1'b0;
    logic       pump_up, pump_dn, pump_en;
    int         n_vec = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    line_phase_cmp i_line_phase_cmp (
        .clk(clk), .rst_n(rst_n), .lock_sel(lock_sel), .tv_sys(tv_sys),
        .sc_pin(sc_pin), .ecs_n(ecs_n), .line_ref_int(line_ref_int),
        .pump_up(pump_up), .pump_dn(pump_dn), .pump_en(pump_en)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_int();
        line_ref_int = 1'b1;
        tick(1);
        line_ref_int = 1'b0;
        tick(3);
    endtask

    task automatic set_cfg(input logic [1:0] s, input logic [2:0] t);
        lock_sel = s;
        tv_sys   = t;
        tick(4);
    endtask

    // Toggle sc_pin until pump_up is seen; report that edge's index (0 if none), then clear.
    task automatic run_sc(input int max_edges, output int hit);
        hit = 0;
        for (int e = 1; e <= max_edges; e++) begin
            sc_pin = 1'b1;
            tick(4);
            sc_pin = 1'b0;
            tick(4);
            if (pump_up) begin
                hit = e;
                break;
            end
        end
        if (hit != 0) pulse_int();
    endtask

    task automatic ecs_pulse(input int w);
        ecs_n = 1'b0;
        tick(w);
        ecs_n = 1'b1;
        tick(8);
    endtask

    task automatic t_reset();
        chk("R1 pump_up", int'(pump_up), 0);
        chk("R1 pump_dn", int'(pump_dn), 0);
        chk("R1 pump_en", int'(pump_en), 0);
    endtask

    task automatic t_leads();
        set_cfg(2'b10, 3'd0);
        sc_pin = 1'b1; tick(8); sc_pin = 1'b0;
        chk("R6 R2 up after ref", int'(pump_up), 1);
        chk("R2 en after ref", int'(pump_en), 1);
        chk("R4 dn idle while up", int'(pump_dn), 0);
        pulse_int();
        chk("R2 up cleared", int'(pump_up), 0);
        chk("R2 en cleared", int'(pump_en), 0);
        pulse_int();
        chk("R3 dn after int", int'(pump_dn), 1);
        chk("R3 en after int", int'(pump_en), 1);
        chk("R4 up idle while dn", int'(pump_up), 0);
        sc_pin = 1'b1; tick(8); sc_pin = 1'b0; tick(4);
        chk("R3 dn cleared", int'(pump_dn), 0);
        chk("R3 en cleared", int'(pump_en), 0);
    endtask

    task automatic t_coincident();
        int lat = 0;
        set_cfg(2'b10, 3'd0);
        sc_pin = 1'b1;
        for (int c = 1; c <= 20; c++) begin
            tick(1);
            if (pump_up) begin
                lat = c;
                break;
            end
        end
        sc_pin = 1'b0;
        pulse_int();
        tick(4);
        sc_pin = 1'b1;
        if (lat > 1) tick(lat - 1);
        line_ref_int = 1'b1;
        tick(1);
        line_ref_int = 1'b0;
        tick(2);
        chk("R11 no up on coincidence", int'(pump_up), 0);
        chk("R11 no dn on coincidence", int'(pump_dn), 0);
        sc_pin = 1'b0;
        tick(4);
    endtask

    task automatic t_frac(input logic [2:0] sys, input longint q, input int k_max);
        int    hit;
        int    total = 0;
        set_cfg(2'b00, sys);
        for (int k = 1; k <= k_max; k++) begin
            longint exp_n = (longint'(k) * q + 9999) / 10000;
            run_sc(400, hit);
            total += hit;
            chk($sformatf("R5 sys%0d pulse%0d edge", sys, k), total, int'(exp_n));
        end
    endtask

    task automatic t_sync(input logic [1:0] sel);
        set_cfg(sel, 3'd0);
        ecs_pulse(110);
        chk("R7 line sync accepted", int'(pump_up), 1);
        pulse_int();
        ecs_pulse(80);
        chk("R7 width at min accepted", int'(pump_up), 1);
        pulse_int();
        ecs_pulse(140);
        chk("R7 width at max accepted", int'(pump_up), 1);
        pulse_int();
        ecs_pulse(79);
        chk("R8 below min rejected", int'(pump_up), 0);
        ecs_pulse(141);
        chk("R8 above max rejected", int'(pump_up), 0);
        ecs_pulse(50);
        chk("R8 equalizing rejected", int'(pump_up), 0);
        ecs_pulse(600);
        chk("R8 broad rejected", int'(pump_up), 0);
        chk("R8 no dn either", int'(pump_dn), 0);
    endtask

    task automatic t_ignore();
        int hit;
        set_cfg(2'b00, 3'd4);
        ecs_pulse(110);
        chk("R9 ecs ignored in subcarrier", int'(pump_up), 0);
        set_cfg(2'b10, 3'd4);
        ecs_pulse(110);
        chk("R9 ecs ignored in ext ref", int'(pump_up), 0);
        set_cfg(2'b01, 3'd4);
        run_sc(300, hit);
        chk("R9 sc ignored in sync lock", hit, 0);
    endtask

    task automatic t_change();
        int hit;
        set_cfg(2'b10, 3'd3);
        sc_pin = 1'b1; tick(8); sc_pin = 1'b0;
        chk("R10 pending before change", int'(pump_up), 1);
        set_cfg(2'b00, 3'd3);
        chk("R10 up cleared by sel change", int'(pump_up), 0);
        for (int e = 0; e < 100; e++) begin
            sc_pin = 1'b1; tick(4); sc_pin = 1'b0; tick(4);
        end
        set_cfg(2'b00, 3'd4);
        run_sc(400, hit);
        chk("R10 count restarts on sys change", hit, 282);
    endtask

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_leads();
        t_coincident();
        t_frac(3'd3, 2275000, 4);
        t_frac(3'd2, 2272500, 4);
        t_frac(3'd4, 2820000, 2);
        t_frac(3'd0, 2837516, 3);
        t_frac(3'd1, 2292516, 3);
        t_frac(3'd6, 2275000, 2);
        t_sync(2'b01);
        t_sync(2'b11);
        t_ignore();
        t_change();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule